// File: doc/BRIEF.md
# Processor Clock and Ready/Reset Synchronizer

This block takes one free-running oscillator-rate clock and derives from it the timing a 16-bit microprocessor system needs. The processor clock is a divide-by-three waveform that is high for one oscillator period and low for two. The peripheral clock is a divide-by-six square wave. Both come from one modulo-6 counter, so they keep a fixed phase to each other. The oscillator itself is also passed straight through to an output, so further clock consumers can be fed from it.

The block also brings two asynchronous system inputs into the processor clock's timing. Two ready requests each count only while their own active-low enable is low. The qualified requests are ORed and then synchronized into a single READY. A pin selects one or two synchronizer stages. An active-low reset request is synchronized to processor rising edges. The result is stretched so that the active-high RESET output always lasts at least four processor periods after the request goes away.

All logic runs on the oscillator clock. The "processor rising edge" and "processor falling edge" are the oscillator edges at which `cpu_clk` goes high or low. Registers hold defined values from power-up, so RESET is already asserted before any request arrives.

Top module: `cpuclk_gen`

## Requirements
- R1: `cpu_clk` is periodic with a period of DIV oscillator cycles (3 by default), so a 15 MHz oscillator gives 5 MHz.
- R2: `cpu_clk` is high for HIGH_CNT oscillator cycles (1 by default) and low for the rest of each period. It is high during the first oscillator cycle after power-up.
- R3: `per_clk` has a period of DIV*PER_MULT oscillator cycles (6 by default) and is high for exactly half of it. Every `per_clk` rising edge falls on the same oscillator edge as a `cpu_clk` rising edge, and `per_clk` is high in the first cycle after power-up.
- R4: `osc_out` carries the oscillator input unchanged.
- R5: Ready input i (bit i of `rdy_req`) contributes only while bit i of `rdy_en_n` is 0. The value that gets synchronized is the OR of the qualified inputs. With every enable high, READY stays 0.
- R6: With `two_stage_n` = 1, `ready_out` takes the qualified ready value at each processor falling edge. It changes at no other edge, so its latency is at most DIV oscillator cycles.
- R7: With `two_stage_n` = 0, the qualified ready is first captured at a processor rising edge. It reaches `ready_out` at the next processor falling edge, so the latency is at most DIV+HIGH_CNT oscillator cycles.
- R8: `reset_out` (1 = reset) is 1 from power-up. After `rst_req_n` goes to 0, it rises at the second processor rising edge, and it changes only at processor rising edges.
- R9: After `rst_req_n` returns to 1, `reset_out` falls at processor rising edge number 2+RST_HOLD (6 by default). That is two synchronizer edges plus RST_HOLD full processor periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator-rate clock; all registers use its rising edge |
| rdy_req | input | N_RDY | Asynchronous ready requests, one bit per source |
| rdy_en_n | input | N_RDY | Active-low enables qualifying each ready request |
| two_stage_n | input | 1 | 0 selects two-stage ready synchronization, 1 selects one stage |
| rst_req_n | input | 1 | Asynchronous active-low reset request |
| osc_out | output | 1 | Oscillator pass-through |
| cpu_clk | output | 1 | Processor clock, divide by DIV, high HIGH_CNT cycles |
| per_clk | output | 1 | Peripheral clock, divide by DIV*PER_MULT, 50% duty |
| ready_out | output | 1 | Synchronized ready |
| reset_out | output | 1 | Synchronized, stretched active-high reset |

## Verification
The bench builds the block with its default parameters: divide by three with a one-cycle high phase, a peripheral multiplier of two, a four-period reset stretch and two ready sources. With these values, every phase of the modulo-6 counter is reached within a few dozen cycles. Both ready sources, both enable states and both synchronizer depths can be stepped through and compared exactly against a behavioural model. The full reset path can also be covered: power-up, assertion and six-edge release.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

   // Strobes marking the oscillator edges at which the processor clock toggles
   typedef struct packed {
      logic rise;
      logic fall;
   } cpu_edge_t;

   function automatic int unsigned cnt_width(input int unsigned modulus);
      return (modulus < 2) ? 1 : $clog2(modulus);
   endfunction

endpackage

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
   import cpuclk_pkg::*;
#(
   parameter int unsigned DIV      = 3,
   parameter int unsigned HIGH_CNT = 1,
   parameter int unsigned PER_MULT = 2
) (
   input  logic      osc_clk,
   output logic      cpu_clk,
   output logic      per_clk,
   output cpu_edge_t edg_o
);
   localparam int unsigned MOD   = DIV * PER_MULT;
   localparam int unsigned CNT_W = cnt_width(MOD);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(MOD - 1);
   localparam logic [CNT_W-1:0] DIV_C  = CNT_W'(DIV);
   localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_CNT);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(MOD / 2);

   if (DIV < 2) begin : g_bad_div
      $error("cpuclk_divider: DIV must be at least 2");
   end
   if (HIGH_CNT < 1 || HIGH_CNT >= DIV) begin : g_bad_high
      $error("cpuclk_divider: HIGH_CNT must lie in 1..DIV-1");
   end
   if (PER_MULT < 1 || (MOD % 2) != 0) begin : g_bad_per
      $error("cpuclk_divider: DIV*PER_MULT must be even for a 50%% peripheral clock");
   end

   logic [CNT_W-1:0] cnt_q = '0;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] phase_q;
   logic [CNT_W-1:0] phase_nxt;
   logic             cpu_q = 1'b1;
   logic             per_q = 1'b1;

   always_comb begin
      cnt_nxt   = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
      phase_q   = cnt_q % DIV_C;
      phase_nxt = cnt_nxt % DIV_C;
   end

   always_ff @(posedge osc_clk) begin
      cnt_q <= cnt_nxt;
      cpu_q <= (phase_nxt < HIGH_C);
      per_q <= (cnt_nxt < HALF_C);
   end

   // Edge strobes: true on the oscillator edge where cpu_clk changes
   always_comb begin
      edg_o.rise = (phase_q == DIV_C - 1'b1);
      edg_o.fall = (phase_q == HIGH_C - 1'b1);
   end

   assign cpu_clk = cpu_q;
   assign per_clk = per_q;

endmodule

// File: rtl/cpuclk_ready_sync.sv
module cpuclk_ready_sync
   import cpuclk_pkg::*;
#(
   parameter int unsigned N_RDY = 2
) (
   input  logic             osc_clk,
   input  cpu_edge_t        edg_i,
   input  logic [N_RDY-1:0] rdy_req,
   input  logic [N_RDY-1:0] rdy_en_n,
   input  logic             two_stage_n,
   output logic             ready_o
);
   if (N_RDY < 1) begin : g_bad_n
      $error("cpuclk_ready_sync: N_RDY must be at least 1");
   end

   logic [N_RDY-1:0] qual_vec;
   logic             qual_any;
   logic             first_q = 1'b0;
   logic             ready_q = 1'b0;

   for (genvar gi = 0; gi < N_RDY; gi++) begin : g_qual
      assign qual_vec[gi] = rdy_req[gi] & ~rdy_en_n[gi];
   end

   assign qual_any = |qual_vec;

   // First stage samples on processor rising edges
   always_ff @(posedge osc_clk) begin
      if (edg_i.rise) begin
         first_q <= qual_any;
      end
   end

   // Output stage updates on processor falling edges
   always_ff @(posedge osc_clk) begin
      if (edg_i.fall) begin
         ready_q <= two_stage_n ? qual_any : first_q;
      end
   end

   assign ready_o = ready_q;

endmodule

// File: rtl/cpuclk_reset_sync.sv
module cpuclk_reset_sync
   import cpuclk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_HOLD    = 4
) (
   input  logic      osc_clk,
   input  cpu_edge_t edg_i,
   input  logic      rst_req_n,
   output logic      reset_o
);
   localparam int unsigned HOLD_W = cnt_width(RST_HOLD + 1);
   localparam logic [HOLD_W-1:0] HOLD_C = HOLD_W'(RST_HOLD);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("cpuclk_reset_sync: SYNC_STAGES must be at least 1");
   end
   if (RST_HOLD < 1) begin : g_bad_hold
      $error("cpuclk_reset_sync: RST_HOLD must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q = '1;
   logic                   req_act;
   logic [HOLD_W-1:0]      hold_q = HOLD_C;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge osc_clk) begin
         if (edg_i.rise) begin
            sync_q <= ~rst_req_n;
         end
      end
   end else begin : g_chain
      always_ff @(posedge osc_clk) begin
         if (edg_i.rise) begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ~rst_req_n};
         end
      end
   end

   assign req_act = sync_q[SYNC_STAGES-1];

   // Stretch counter: reloaded while the request is active, counts down after
   always_ff @(posedge osc_clk) begin
      if (edg_i.rise) begin
         if (req_act) begin
            hold_q <= HOLD_C;
         end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
         end
      end
   end

   assign reset_o = req_act | (hold_q != '0);

endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
   import cpuclk_pkg::*;
#(
   parameter int unsigned DIV         = 3,
   parameter int unsigned HIGH_CNT    = 1,
   parameter int unsigned PER_MULT    = 2,
   parameter int unsigned N_RDY       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_HOLD    = 4
) (
   input  logic             osc_clk,
   input  logic [N_RDY-1:0] rdy_req,
   input  logic [N_RDY-1:0] rdy_en_n,
   input  logic             two_stage_n,
   input  logic             rst_req_n,
   output logic             osc_out,
   output logic             cpu_clk,
   output logic             per_clk,
   output logic             ready_out,
   output logic             reset_out
);
   cpu_edge_t edg;

   cpuclk_divider #(
      .DIV      (DIV),
      .HIGH_CNT (HIGH_CNT),
      .PER_MULT (PER_MULT)
   ) div_i (
      .osc_clk (osc_clk),
      .cpu_clk (cpu_clk),
      .per_clk (per_clk),
      .edg_o   (edg)
   );

   cpuclk_ready_sync #(
      .N_RDY (N_RDY)
   ) rdy_i (
      .osc_clk     (osc_clk),
      .edg_i       (edg),
      .rdy_req     (rdy_req),
      .rdy_en_n    (rdy_en_n),
      .two_stage_n (two_stage_n),
      .ready_o     (ready_out)
   );

   cpuclk_reset_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .RST_HOLD    (RST_HOLD)
   ) rst_i (
      .osc_clk   (osc_clk),
      .edg_i     (edg),
      .rst_req_n (rst_req_n),
      .reset_o   (reset_out)
   );

   assign osc_out = osc_clk;

endmodule

// File: rtl/cpuclk_gen_chk.sv
module cpuclk_gen_chk #(
   parameter int unsigned DIV      = 3,
   parameter int unsigned HIGH_CNT = 1,
   parameter int unsigned PER_MULT = 2,
   parameter int unsigned RST_HOLD = 4,
   parameter int unsigned N_RDY    = 2
) (
   input logic             osc_clk,
   input logic [N_RDY-1:0] rdy_req,
   input logic [N_RDY-1:0] rdy_en_n,
   input logic             two_stage_n,
   input logic             rst_req_n,
   input logic             cpu_clk,
   input logic             per_clk,
   input logic             ready_out,
   input logic             reset_out
);
   localparam int unsigned PER_HALF = DIV * PER_MULT / 2;

   logic       warm    = 1'b0;
   logic       cpu_d   = 1'b1;
   logic [7:0] hi_run  = 8'd0;
   logic [7:0] lo_run  = 8'd0;
   logic [7:0] phi_run = 8'd0;
   logic [7:0] plo_run = 8'd0;
   logic [7:0] rel_cnt = 8'd0;

   always_ff @(posedge osc_clk) begin
      cpu_d   <= cpu_clk;
      warm    <= warm | (cpu_clk & ~cpu_d);
      hi_run  <= cpu_clk ? hi_run + 8'd1 : 8'd0;
      lo_run  <= cpu_clk ? 8'd0 : lo_run + 8'd1;
      phi_run <= per_clk ? phi_run + 8'd1 : 8'd0;
      plo_run <= per_clk ? 8'd0 : plo_run + 8'd1;
      if (!rst_req_n) begin
         rel_cnt <= 8'd0;
      end else if (cpu_clk && !cpu_d && rel_cnt != 8'hFF) begin
         rel_cnt <= rel_cnt + 8'd1;
      end
   end

   // R2
   cpu_high_len_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      $fell(cpu_clk) |-> (hi_run == 8'(HIGH_CNT)));

   // R1
   cpu_low_len_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      $rose(cpu_clk) |-> (lo_run == 8'(DIV - HIGH_CNT)));

   // R3
   per_high_len_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      $fell(per_clk) |-> (phi_run == 8'(PER_HALF)));

   // R3
   per_low_len_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      $rose(per_clk) |-> (plo_run == 8'(PER_HALF)));

   // R3
   per_phase_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      $rose(per_clk) |-> $rose(cpu_clk));

   // R6 R7
   ready_edge_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      !$stable(ready_out) |-> $fell(cpu_clk));

   // R5
   ready_qual_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      ($rose(ready_out) && two_stage_n && $past(two_stage_n))
         |-> $past(|(rdy_req & ~rdy_en_n)));

   // R8
   reset_edge_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      !$stable(reset_out) |-> $rose(cpu_clk));

   // R9
   reset_stretch_chk: assert property (@(posedge osc_clk) disable iff (!warm)
      $fell(reset_out) |-> (rel_cnt >= 8'(RST_HOLD)));

endmodule

bind cpuclk_gen cpuclk_gen_chk #(
   .DIV      (DIV),
   .HIGH_CNT (HIGH_CNT),
   .PER_MULT (PER_MULT),
   .RST_HOLD (RST_HOLD),
   .N_RDY    (N_RDY)
) chk_i (
   .osc_clk     (osc_clk),
   .rdy_req     (rdy_req),
   .rdy_en_n    (rdy_en_n),
   .two_stage_n (two_stage_n),
   .rst_req_n   (rst_req_n),
   .cpu_clk     (cpu_clk),
   .per_clk     (per_clk),
   .ready_out   (ready_out),
   .reset_out   (reset_out)
);

// File: tb/cpuclk_gen_tb_top.sv
module cpuclk_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 3;
   localparam int HIGH_CNT   = 1;
   localparam int PER_MULT   = 2;
   localparam int N_RDY      = 2;
   localparam int RST_HOLD   = 4;
   localparam int PER_MOD    = DIV * PER_MULT;

   logic             osc_clk = 1'b0;
   logic [N_RDY-1:0] rdy_req = '0;
   logic [N_RDY-1:0] rdy_en_n = '1;
   logic             two_stage_n = 1'b1;
   logic             rst_req_n = 1'b1;
   logic             osc_out, cpu_clk, per_clk, ready_out, reset_out;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   cpuclk_gen #(
      .DIV(DIV), .HIGH_CNT(HIGH_CNT), .PER_MULT(PER_MULT),
      .N_RDY(N_RDY), .SYNC_STAGES(2), .RST_HOLD(RST_HOLD)
   ) dut_i (
      .osc_clk(osc_clk), .rdy_req(rdy_req), .rdy_en_n(rdy_en_n),
      .two_stage_n(two_stage_n), .rst_req_n(rst_req_n),
      .osc_out(osc_out), .cpu_clk(cpu_clk), .per_clk(per_clk),
      .ready_out(ready_out), .reset_out(reset_out)
   );

   always #(CLK_PERIOD / 2) osc_clk = ~osc_clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Behavioural reference model, advanced on every oscillator edge
   int m_n   = 0;
   bit m_s1  = 0;
   bit m_rdy = 0;
   bit m_r0  = 1;
   bit m_r1  = 1;
   int m_rc  = RST_HOLD;
   bit cmp_on = 1;

   always @(posedge osc_clk) begin
      int ph;
      bit q;
      ph = m_n % DIV;
      q  = |(rdy_req & ~rdy_en_n);
      if (ph == HIGH_CNT - 1) m_rdy = two_stage_n ? q : m_s1;
      if (ph == DIV - 1) begin
         m_s1 = q;
         if (m_r1) m_rc = RST_HOLD;
         else if (m_rc > 0) m_rc = m_rc - 1;
         m_r1 = m_r0;
         m_r0 = !rst_req_n;
      end
      m_n = m_n + 1;
      cyc = cyc + 1;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   always @(negedge osc_clk) begin
      if (cmp_on) begin
         check("R1 R2 cpu_clk vs model", int'(cpu_clk), int'((m_n % DIV) < HIGH_CNT));
         check("R3 per_clk vs model", int'(per_clk), int'((m_n % PER_MOD) < PER_MOD / 2));
         check("R5 R6 R7 ready_out vs model", int'(ready_out), int'(m_rdy));
         check("R8 R9 reset_out vs model", int'(reset_out), int'(m_r1 || m_rc > 0));
      end
   end

   // Counts processor rising edges until reset_out reaches target level
   task automatic rises_until_reset(input bit target, output int n);
      bit prev;
      n = 0;
      prev = cpu_clk;
      for (int i = 0; i < 200; i++) begin
         @(negedge osc_clk);
         if (cpu_clk && !prev) n++;
         prev = cpu_clk;
         if (reset_out == target) break;
      end
   endtask

   task automatic cycles_until_ready(input bit target, output int n);
      n = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge osc_clk);
         n++;
         if (ready_out == target) break;
      end
   endtask

   initial begin
      int n;
      int last_rise, hi_cnt, per_hi, per_last;
      bit prev_c, prev_p;
      int lfsr;

      #1;
      check("R2 cpu_clk high after power-up", int'(cpu_clk), 1);
      check("R3 per_clk high after power-up", int'(per_clk), 1);
      check("R8 reset_out high after power-up", int'(reset_out), 1);
      check("R6 ready_out low after power-up", int'(ready_out), 0);
      #(CLK_PERIOD / 2);
      check("R4 osc_out high with oscillator", int'(osc_out), 1);
      #(CLK_PERIOD / 2);
      check("R4 osc_out low with oscillator", int'(osc_out), 0);

      // R9: power-up stretch ends at rising edge 2+RST_HOLD
      rises_until_reset(1'b0, n);
      check("R9 rises to power-up reset release", n, 2 + RST_HOLD);

      // R1 R2 R3: measure periods and high widths
      last_rise = -1; per_last = -1; hi_cnt = 0; per_hi = 0;
      prev_c = cpu_clk; prev_p = per_clk;
      for (int i = 0; i < 30; i++) begin
         @(negedge osc_clk);
         if (cpu_clk && !prev_c) begin
            if (last_rise >= 0) begin
               check("R1 cpu_clk period", i - last_rise, DIV);
               check("R2 cpu_clk high cycles", hi_cnt, HIGH_CNT);
            end
            last_rise = i; hi_cnt = 0;
         end
         if (per_clk && !prev_p) begin
            check("R3 per_clk rises with cpu_clk", int'(cpu_clk && !prev_c), 1);
            if (per_last >= 0) begin
               check("R3 per_clk period", i - per_last, PER_MOD);
               check("R3 per_clk high cycles", per_hi, PER_MOD / 2);
            end
            per_last = i; per_hi = 0;
         end
         if (cpu_clk) hi_cnt++;
         if (per_clk) per_hi++;
         prev_c = cpu_clk; prev_p = per_clk;
      end

      // R5: requests with enables high are ignored
      two_stage_n = 1'b1;
      rdy_req = 2'b11; rdy_en_n = 2'b11;
      repeat (12) @(negedge osc_clk);
      check("R5 ready stays low with enables high", int'(ready_out), 0);

      // R6: single-stage latency, source 0
      rdy_en_n = 2'b10;
      cycles_until_ready(1'b1, n);
      check("R6 single-stage rise latency bound", int'(n <= DIV), 1);
      rdy_req = 2'b10;
      cycles_until_ready(1'b0, n);
      check("R5 R6 request on disabled source dropped", int'(n <= DIV), 1);
      rdy_en_n = 2'b01;
      cycles_until_ready(1'b1, n);
      check("R5 source 1 qualified", int'(ready_out), 1);

      // R7: two-stage latency
      two_stage_n = 1'b0;
      rdy_req = 2'b00;
      cycles_until_ready(1'b0, n);
      check("R7 two-stage fall latency bound", int'(n <= DIV + HIGH_CNT), 1);
      rdy_req = 2'b01; rdy_en_n = 2'b00;
      cycles_until_ready(1'b1, n);
      check("R7 two-stage rise latency bound", int'(n <= DIV + HIGH_CNT), 1);
      check("R7 two-stage latency above single", int'(n > HIGH_CNT), 1);

      // R8 R9: reset request during operation
      rst_req_n = 1'b0;
      rises_until_reset(1'b1, n);
      check("R8 rises to reset assertion", n, 2);
      repeat (10) @(negedge osc_clk);
      check("R8 reset held while requested", int'(reset_out), 1);
      rst_req_n = 1'b1;
      rises_until_reset(1'b0, n);
      check("R9 rises to reset release", n, 2 + RST_HOLD);

      // Mixed pattern compared against model every cycle
      lfsr = 32'h1d5;
      for (int i = 0; i < 400; i++) begin
         @(negedge osc_clk);
         lfsr = (lfsr << 1) ^ (((lfsr >> 8) ^ (lfsr >> 4)) & 1);
         if ((lfsr & 7) == 0) rdy_req = 2'(lfsr >> 3);
         if ((lfsr & 15) == 5) rdy_en_n = 2'(lfsr >> 5);
         if ((lfsr & 63) == 9) two_stage_n = ~two_stage_n;
         if ((lfsr & 127) == 17) rst_req_n = ~rst_req_n;
      end
      rst_req_n = 1'b1;
      repeat (40) @(negedge osc_clk);
      check("R9 reset released at end", int'(reset_out), 0);

      finish_run();
   end

endmodule